// File: doc/BRIEF.md
# Free/Ready Page DMA Manager

This block turns a stream of 32-bit link words into 64-bit writes to host memory pages, with no processor in the data path. Host software hands the block empty pages by pushing their base addresses into a free-page queue. When the first word of a page arrives, the block takes the next address from that queue. It packs pairs of words into 64-bit beats and issues each beat on a plain address/data/valid/ready write master. When a page fills, or the current event ends, it writes a completion entry into a ready queue. Software drains that queue.

A completion entry holds the page base address, the number of bytes written and two flags: end-of-event and error. An event longer than one page carries on at offset zero of the next free page, and only the last page of the event is marked end-of-event. When the block holds no page and the free queue is empty, it raises `busy` and stops accepting input. It also stops accepting input while a closed page is waiting for room in a full ready queue.

Top module: `page_dma_mgr`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 1, `in_ready` is 0, `mem_valid` is 0, `rdy_empty` is 1 and `free_full` is 0.
- R2: A pulse on `free_wr_en` queues `free_wr_addr` unless `free_full` is high, in which case the address is dropped. `free_full` is high while FREE_DEPTH addresses are queued. Pages are used in the order they were queued.
- R3: `busy` is 1 exactly when no page is open and the free queue is empty. While `busy` is 1, `in_ready` is 0.
- R4: Two consecutively accepted words form one 64-bit beat, with the earlier word in bits 31:0. A beat's address is the page base plus 8 times the beat's index in the page, so bits 2:0 of `mem_addr` are always 0.
- R5: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr` and `mem_data` hold steady. No input word is accepted while a beat is outstanding.
- R6: When the bytes written to a page reach PAGE_BYTES, the page closes with length PAGE_BYTES and end-of-event 0. The next word of the same event goes to offset 0 of the next free page.
- R7: A word accepted with `in_last` = 1 closes the page. The entry has end-of-event 1 and holds the number of bytes written to that page.
- R8: An odd final word of a page is written as a beat with zeros in bits 63:32, and it adds 4 (not 8) to the entry length.
- R9: The entry's error flag is 1 if and only if some word accepted into that page had `in_err` = 1.
- R10: A completion entry is queued only after the page's final beat has been accepted by the memory master. While the ready queue is full, the entry waits and `in_ready` stays 0.
- R11: While `rdy_empty` is 0, the `rdy_*` outputs show the oldest entry, and entries come out in the order pages closed. `rdy_rd_en` removes that entry. `rdy_rd_en` has no effect while `rdy_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| free_wr_en | input | 1 | Queue a free page address |
| free_wr_addr | input | ADDR_W | Base address of a free page |
| free_full | output | 1 | Free-page queue is full |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word |
| in_last | input | 1 | This word ends the event |
| in_err | input | 1 | This word is flagged as errored |
| in_ready | output | 1 | Input word is accepted on this edge |
| busy | output | 1 | No page open and no free page queued |
| mem_valid | output | 1 | Write beat present |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_data | output | 64 | Beat data |
| mem_ready | input | 1 | Memory master takes the beat |
| rdy_rd_en | input | 1 | Remove the head completion entry |
| rdy_empty | output | 1 | Ready queue is empty |
| rdy_page_addr | output | ADDR_W | Head entry page base |
| rdy_len | output | LEN_W | Head entry length in bytes |
| rdy_eoe | output | 1 | Head entry ends an event |
| rdy_err | output | 1 | Head entry saw an errored word |

## Verification
The bench builds the block with 32-byte pages (four beats), a free queue four entries deep and a ready queue two entries deep. With pages that small, a ten-word event crosses a page boundary, and the ready queue fills after two pages. That lets the held close, the input stall behind it and the reuse of a page address after a dropped push all happen within a few hundred cycles. During one phase `mem_ready` drops on every third cycle, so beats have to be held across stalls.

// File: rtl/pdm_pkg.sv
// Shared constants and types for the page DMA manager.
// Assumes a 32-bit input word and a 64-bit memory beat.
package pdm_pkg;
    localparam int WORD_W     = 32;
    localparam int BEAT_W     = 64;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BEAT_BYTES = BEAT_W / 8;

    // Status flags carried with each completion entry
    typedef struct packed {
        logic eoe;
        logic err;
    } pdm_flags_t;
endpackage

// File: rtl/pdm_fifo.sv
// Synchronous show-ahead FIFO.
// A push while full and a pop while empty are both ignored.
// Storage is not reset; only the pointers and the count are.
module pdm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push;
    logic             do_pop;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CNT_W'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = store[rd_ptr];

    // Write the incoming entry at the tail slot
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers with wrap-around and keep the fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/pdm_writer.sv
// Page writer engine. It opens a page from the free queue on the first
// word, packs word pairs into 64-bit beats, and drives a single beat
// register toward memory. It closes the page when the page is full or
// the event ends. The completion entry is released only after the last
// beat is accepted and the ready queue has room.
// Assumes page bases are aligned to PAGE_BYTES and PAGE_BYTES >= 8.
module pdm_writer
    import pdm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int LEN_W      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_err,
    output logic              in_ready,
    output logic              busy,
    input  logic              fr_empty,
    input  logic [ADDR_W-1:0] fr_head,
    output logic              fr_pop,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_data,
    input  logic              mem_ready,
    input  logic              rq_full,
    output logic              rq_push,
    output logic [ADDR_W-1:0] rq_addr,
    output logic [LEN_W-1:0]  rq_len,
    output pdm_flags_t        rq_flags
);
    logic              have_page;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  cnt;
    logic              err_acc;
    logic [WORD_W-1:0] lo_word;
    logic              beat_v;
    logic              close_pend;
    logic [LEN_W-1:0]  pend_len;
    logic              pend_eoe;
    logic              pend_err;

    logic [ADDR_W-1:0] cur_base;
    logic [LEN_W-1:0]  cnt_next;
    logic [LEN_W-1:0]  beat_ofs;
    logic              take;
    logic              beat_end;
    logic              page_end;
    logic              close_go;

    // Handshake and page decisions for the current cycle
    always_comb begin
        busy     = !have_page && fr_empty;
        in_ready = !beat_v && !close_pend && !busy;
        take     = in_valid && in_ready;
        fr_pop   = take && !have_page;
        cur_base = have_page ? base : fr_head;
        cnt_next = cnt + LEN_W'(WORD_BYTES);
        beat_ofs = {cnt[LEN_W-1:3], 3'b000};
        beat_end = !cnt_next[2] || in_last;
        page_end = (cnt_next == LEN_W'(PAGE_BYTES)) || in_last;
        close_go = close_pend && !beat_v && !rq_full;
    end

    assign rq_push   = close_go;
    assign rq_addr   = base;
    assign rq_len    = pend_len;
    assign rq_flags  = '{eoe: pend_eoe, err: pend_err};
    assign mem_valid = beat_v;

    // Track the open page, its byte count and its sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_page <= 1'b0;
            base      <= '0;
            cnt       <= '0;
            err_acc   <= 1'b0;
        end else if (close_go) begin
            have_page <= 1'b0;
            cnt       <= '0;
            err_acc   <= 1'b0;
        end else if (take) begin
            have_page <= 1'b1;
            base      <= cur_base;
            cnt       <= cnt_next;
            err_acc   <= err_acc | in_err;
        end
    end

    // Record a page close and hold it until the ready queue takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            close_pend <= 1'b0;
            pend_len   <= '0;
            pend_eoe   <= 1'b0;
            pend_err   <= 1'b0;
        end else if (close_go) begin
            close_pend <= 1'b0;
        end else if (take && page_end) begin
            close_pend <= 1'b1;
            pend_len   <= cnt_next;
            pend_eoe   <= in_last;
            pend_err   <= err_acc | in_err;
        end
    end

    // Hold the lower word of a beat until its partner arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_word <= '0;
        end else if (take && !beat_end) begin
            lo_word <= in_data;
        end
    end

    // Load a finished beat and keep it until the memory master takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_v   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else if (take && beat_end) begin
            beat_v   <= 1'b1;
            mem_addr <= cur_base + ADDR_W'(beat_ofs);
            mem_data <= cnt[2] ? {in_data, lo_word} : {{WORD_W{1'b0}}, in_data};
        end else if (beat_v && mem_ready) begin
            beat_v <= 1'b0;
        end
    end
endmodule

// File: rtl/page_dma_mgr.sv
// Free/ready page DMA manager top. Software fills a queue of free page
// addresses, the writer engine moves link words into those pages, and
// a queue of completion entries goes back to software.
// Assumes page addresses are PAGE_BYTES aligned.
module page_dma_mgr
    import pdm_pkg::*;
#(
    parameter  int ADDR_W      = 32,
    parameter  int PAGE_BYTES  = 4096,
    parameter  int FREE_DEPTH  = 16,
    parameter  int READY_DEPTH = 16,
    localparam int LEN_W       = $clog2(PAGE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              free_wr_en,
    input  logic [ADDR_W-1:0] free_wr_addr,
    output logic              free_full,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    input  logic              in_last,
    input  logic              in_err,
    output logic              in_ready,
    output logic              busy,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_data,
    input  logic              mem_ready,
    input  logic              rdy_rd_en,
    output logic              rdy_empty,
    output logic [ADDR_W-1:0] rdy_page_addr,
    output logic [LEN_W-1:0]  rdy_len,
    output logic              rdy_eoe,
    output logic              rdy_err
);
    localparam int RQ_W = ADDR_W + LEN_W + $bits(pdm_flags_t);

    logic              fr_empty;
    logic [ADDR_W-1:0] fr_head;
    logic              fr_pop;
    logic              rq_full;
    logic              rq_push;
    logic [ADDR_W-1:0] rq_addr;
    logic [LEN_W-1:0]  rq_len;
    pdm_flags_t        rq_flags;
    logic [RQ_W-1:0]   rq_head;
    pdm_flags_t        head_flags;

    pdm_fifo #(.W(ADDR_W), .DEPTH(FREE_DEPTH)) u_free_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (free_wr_en),
        .push_data (free_wr_addr),
        .pop       (fr_pop),
        .pop_data  (fr_head),
        .empty     (fr_empty),
        .full      (free_full)
    );

    pdm_writer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_err    (in_err),
        .in_ready  (in_ready),
        .busy      (busy),
        .fr_empty  (fr_empty),
        .fr_head   (fr_head),
        .fr_pop    (fr_pop),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_ready (mem_ready),
        .rq_full   (rq_full),
        .rq_push   (rq_push),
        .rq_addr   (rq_addr),
        .rq_len    (rq_len),
        .rq_flags  (rq_flags)
    );

    pdm_fifo #(.W(RQ_W), .DEPTH(READY_DEPTH)) u_ready_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rq_push),
        .push_data ({rq_addr, rq_len, rq_flags}),
        .pop       (rdy_rd_en),
        .pop_data  (rq_head),
        .empty     (rdy_empty),
        .full      (rq_full)
    );

    // Split the head completion entry into its fields
    always_comb begin
        rdy_page_addr = rq_head[RQ_W-1 -: ADDR_W];
        rdy_len       = rq_head[$bits(pdm_flags_t) +: LEN_W];
        head_flags    = pdm_flags_t'(rq_head[$bits(pdm_flags_t)-1:0]);
        rdy_eoe       = head_flags.eoe;
        rdy_err       = head_flags.err;
    end
endmodule

// File: rtl/page_dma_mgr_chk.sv
// Protocol checker for page_dma_mgr, attached through bind.
module page_dma_mgr_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              busy,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_data,
    input logic              mem_ready,
    input logic              rdy_rd_en,
    input logic              rdy_empty,
    input logic [ADDR_W-1:0] rdy_page_addr,
    input logic [LEN_W-1:0]  rdy_len
);
    // R5
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R5
    no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !in_ready);

    // R3
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R4
    beat_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[2:0] == 3'b000));

    // R11
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_empty && !rdy_rd_en |=> !rdy_empty && $stable(rdy_page_addr) && $stable(rdy_len));
endmodule

bind page_dma_mgr page_dma_mgr_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .busy          (busy),
    .mem_valid     (mem_valid),
    .mem_addr      (mem_addr),
    .mem_data      (mem_data),
    .mem_ready     (mem_ready),
    .rdy_rd_en     (rdy_rd_en),
    .rdy_empty     (rdy_empty),
    .rdy_page_addr (rdy_page_addr),
    .rdy_len       (rdy_len)
);

// File: tb/page_dma_mgr_bench.sv
`timescale 1ns/1ps
module page_dma_mgr_bench;
    localparam int AW = 32;
    localparam int PB = 32;
    localparam int FD = 4;
    localparam int RD = 2;
    localparam int LW = $clog2(PB) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          free_wr_en = 1'b0;
    logic [AW-1:0] free_wr_addr = '0;
    logic          free_full;
    logic          in_valid = 1'b0;
    logic [31:0]   in_data = '0;
    logic          in_last = 1'b0;
    logic          in_err = 1'b0;
    logic          in_ready;
    logic          busy;
    logic          mem_valid;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_data;
    logic          mem_ready = 1'b1;
    logic          rdy_rd_en = 1'b0;
    logic          rdy_empty;
    logic [AW-1:0] rdy_page_addr;
    logic [LW-1:0] rdy_len;
    logic          rdy_eoe;
    logic          rdy_err;

    int errors = 0;
    int checks = 0;
    bit chk_on = 1'b0;
    bit mr_mode = 1'b0;
    int cyc = 0;

    always #2 clk = ~clk;

    page_dma_mgr #(.ADDR_W(AW), .PAGE_BYTES(PB), .FREE_DEPTH(FD), .READY_DEPTH(RD)) u_page_dma_mgr (
        .clk(clk), .rst_n(rst_n),
        .free_wr_en(free_wr_en), .free_wr_addr(free_wr_addr), .free_full(free_full),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .in_ready(in_ready), .busy(busy),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
        .rdy_rd_en(rdy_rd_en), .rdy_empty(rdy_empty), .rdy_page_addr(rdy_page_addr),
        .rdy_len(rdy_len), .rdy_eoe(rdy_eoe), .rdy_err(rdy_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference state
    logic [AW-1:0]      m_free[$];
    logic [AW+LW+1:0]   m_rdy[$];
    bit                 m_have, m_bv, m_cp, m_err, m_peoe, m_perr;
    logic [AW-1:0]      m_base, m_baddr;
    int                 m_cnt, m_plen;
    logic [31:0]        m_lo;
    logic [63:0]        m_bdata;

    always @(posedge clk) begin : model
        int fsz, rsz, ofs;
        bit inr, acc, cpush, rpop, hs;
        logic [AW-1:0] b;
        if (!rst_n) begin
            m_free.delete(); m_rdy.delete();
            m_have = 0; m_bv = 0; m_cp = 0; m_err = 0; m_cnt = 0;
        end else begin
            fsz   = m_free.size();
            rsz   = m_rdy.size();
            inr   = !m_bv && !m_cp && (m_have || fsz > 0);
            acc   = in_valid && inr;
            cpush = m_cp && !m_bv && (rsz < RD);
            rpop  = rdy_rd_en && (rsz > 0);
            hs    = m_bv && mem_ready;
            if (hs) m_bv = 0;
            if (rpop) void'(m_rdy.pop_front());
            if (cpush) begin
                m_rdy.push_back({m_base, LW'(m_plen), m_peoe, m_perr});
                m_cp = 0; m_have = 0; m_cnt = 0; m_err = 0;
            end
            if (acc) begin
                b = m_have ? m_base : m_free.pop_front();
                m_have = 1; m_base = b;
                ofs = m_cnt; m_cnt += 4; m_err = m_err | in_err;
                if ((m_cnt % 8 == 0) || in_last) begin
                    m_bv = 1;
                    m_baddr = b + AW'((ofs / 8) * 8);
                    m_bdata = (ofs % 8 == 4) ? {in_data, m_lo} : {32'h0, in_data};
                end else begin
                    m_lo = in_data;
                end
                if ((m_cnt == PB) || in_last) begin
                    m_cp = 1; m_plen = m_cnt; m_peoe = in_last; m_perr = m_err;
                end
            end
            if (free_wr_en && fsz < FD) m_free.push_back(free_wr_addr);
        end
    end

    // Compare every output against the reference, away from the active edge
    always @(negedge clk) begin : compare
        bit e_inr, e_busy;
        logic [AW+LW+1:0] h;
        if (chk_on) begin
            e_busy = !m_have && (m_free.size() == 0);
            e_inr  = !m_bv && !m_cp && !e_busy;
            check(busy === e_busy, "R3", "busy", 64'(busy), 64'(e_busy));
            check(in_ready === e_inr, "R5/R10", "in_ready", 64'(in_ready), 64'(e_inr));
            check(free_full === (m_free.size() == FD), "R2", "free_full",
                  64'(free_full), 64'(m_free.size() == FD));
            check(mem_valid === m_bv, "R5", "mem_valid", 64'(mem_valid), 64'(m_bv));
            if (m_bv) begin
                check(mem_addr === m_baddr, "R4", "mem_addr", 64'(mem_addr), 64'(m_baddr));
                check(mem_data === m_bdata, "R4/R8", "mem_data", mem_data, m_bdata);
            end
            check(rdy_empty === (m_rdy.size() == 0), "R11", "rdy_empty",
                  64'(rdy_empty), 64'(m_rdy.size() == 0));
            if (m_rdy.size() > 0) begin
                h = m_rdy[0];
                check({rdy_page_addr, rdy_len, rdy_eoe, rdy_err} === h, "R11", "ready head",
                      64'({rdy_page_addr, rdy_len, rdy_eoe, rdy_err}), 64'(h));
            end
        end
    end

    // Memory-side acceptance pattern
    always @(negedge clk) begin
        cyc++;
        mem_ready = mr_mode ? (cyc % 3 != 0) : 1'b1;
    end

    task automatic push_free(input logic [AW-1:0] a);
        free_wr_en = 1'b1; free_wr_addr = a;
        @(negedge clk);
        free_wr_en = 1'b0;
    endtask

    task automatic send(input logic [31:0] d, input bit l, input bit e);
        in_valid = 1'b1; in_data = d; in_last = l; in_err = e;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    endtask

    task automatic pop_entry(input logic [AW-1:0] a, input int len, input bit eoe,
                             input bit err, input string req);
        while (rdy_empty) @(negedge clk);
        check(rdy_page_addr === a, req, "entry addr", 64'(rdy_page_addr), 64'(a));
        check(rdy_len === LW'(len), req, "entry len", 64'(rdy_len), 64'(len));
        check(rdy_eoe === eoe, req, "entry eoe", 64'(rdy_eoe), 64'(eoe));
        check(rdy_err === err, req, "entry err", 64'(rdy_err), 64'(err));
        rdy_rd_en = 1'b1;
        @(negedge clk);
        rdy_rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R1 reset state
        check(busy === 1'b1, "R1", "busy", 64'(busy), 64'd1);
        check(in_ready === 1'b0, "R1", "in_ready", 64'(in_ready), 64'd0);
        check(mem_valid === 1'b0, "R1", "mem_valid", 64'(mem_valid), 64'd0);
        check(rdy_empty === 1'b1, "R1", "rdy_empty", 64'(rdy_empty), 64'd1);
        check(free_full === 1'b0, "R1", "free_full", 64'(free_full), 64'd0);

        for (int i = 1; i <= 4; i++) push_free(AW'(i * 32'h1000));
        check(free_full === 1'b1, "R2", "full after four", 64'(free_full), 64'd1);
        push_free(32'h5000);            // dropped: queue full (R2)
        check(busy === 1'b0, "R3", "busy with pages", 64'(busy), 64'd0);

        // Event A: three words, odd tail (R7, R8)
        send(32'hA000_0000, 0, 0);
        send(32'hA000_0001, 0, 0);
        send(32'hA000_0002, 1, 0);
        repeat (3) @(negedge clk);

        // Event B: ten words across a page, memory stalling (R6, R10)
        mr_mode = 1'b1;
        for (int i = 0; i < 10; i++) send(32'hB000_0000 + 32'(i), i == 9, 0);
        repeat (6) @(negedge clk);
        check(in_ready === 1'b0, "R10", "stall on full ready queue", 64'(in_ready), 64'd0);
        check(rdy_empty === 1'b0, "R10", "ready queue holds", 64'(rdy_empty), 64'd0);

        pop_entry(32'h1000, 12, 1, 0, "R7/R8/R9");
        pop_entry(32'h2000, 32, 0, 0, "R6");
        pop_entry(32'h3000, 8, 1, 0, "R6/R10");

        // Event C: errored word (R9)
        send(32'hC000_0000, 0, 0);
        send(32'hC000_0001, 1, 1);
        pop_entry(32'h4000, 8, 1, 1, "R9");
        repeat (3) @(negedge clk);
        check(busy === 1'b1, "R3", "busy when drained", 64'(busy), 64'd1);
        check(in_ready === 1'b0, "R3", "in_ready when drained", 64'(in_ready), 64'd0);

        // Read while empty has no effect (R11)
        rdy_rd_en = 1'b1;
        @(negedge clk);
        rdy_rd_en = 1'b0;
        check(rdy_empty === 1'b1, "R11", "read while empty", 64'(rdy_empty), 64'd1);

        // Event D on a fresh page; the dropped address must not appear (R2, R8)
        push_free(32'h6000);
        send(32'hD000_0000, 1, 0);
        pop_entry(32'h6000, 4, 1, 0, "R2/R8");

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule